// File: doc/BRIEF.md
# Modulo and Bit-Reverse Address ALU

This block computes effective addresses for a DSP data path. It keeps a small file of register triplets. Each triplet holds an address, an offset and a modifier. In each clock cycle the block can post-update one selected address register. The value held in that triplet's modifier selects the arithmetic: plain linear stepping, a circular buffer of any length (modulo), a power-of-two ring that may wrap many times in one step (multiple-wrap modulo), or reverse-carry stepping for bit-reversed FFT access.

The address before the update is driven out for the current memory access. The updated address is driven out in the same cycle and written back at the next rising clock edge. Three adders run side by side on the same operands: a forward adder, a reverse-carry adder and a modulo correction adder. A decode of the modifier picks one of their results. Software loads the triplets through a single write port. When a load and an update hit the same address register in one cycle, the load wins.

Top module: `modulo_brev_agu`

## Requirements
- R1: After reset, every address and offset register is zero and every modifier is all ones (linear). `curAddr` therefore reads 0 for every index, and an increment yields 1.
- R2: When `wrEn` is high, `wrData` is stored at the rising edge into the register of triplet `wrIdx` chosen by `wrSel`: 0 = address, 1 = offset, 2 = modifier. `wrSel` = 3 changes no register.
- R3: Linear mode applies when the modifier is all ones, and also for any modifier value that R4 to R6 do not name. The result is address plus step modulo 2^24. The step is selected by `updOp`: 0 = +1, 1 = −1, 2 or 3 = the triplet's offset taken as a signed 24-bit value.
- R4: A modifier M in 1..0x7FFF selects modulo mode with length M+1. The buffer base is the address with its low bits cleared, where the number of cleared bits is the bit width of M. For an address inside base..base+M and a step of magnitude at most M+1, the result wraps at most once and stays inside base..base+M.
- R5: A modifier of 0x8000 + L, where L is 2^k−1 for k = 1..8, selects multiple-wrap mode. The low k bits of the result are the low k bits of address plus step. All higher bits are kept from the old address.
- R6: A modifier of 0 selects reverse-carry mode. The address and the step are added with the carry running from the MSB toward the LSB. Starting at 0 with an offset of 4, successive updates give 0, 4, 2, 6, 1, 5, 3, 7.
- R7: `curAddr` always shows the address register selected by `updIdx`. `nextAddr` shows the result of the update. When `updEn` is high, only that register takes `nextAddr` at the edge.
- R8: When an address load and an update target the same triplet in one cycle, the register takes the loaded value.
- R9: While `updEn` and `wrEn` are both low, no address register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register load strobe |
| wrSel | input | 2 | Load target: 0 address, 1 offset, 2 modifier, 3 none |
| wrIdx | input | 2 | Triplet index for the load |
| wrData | input | 24 | Load value |
| updEn | input | 1 | Address update request |
| updIdx | input | 2 | Triplet index for the update and for `curAddr` |
| updOp | input | 2 | Step: 0 +1, 1 −1, 2/3 add offset |
| curAddr | output | 24 | Address before the update |
| nextAddr | output | 24 | Updated address |

## Verification
The bench uses the default parameters: a 24-bit datapath, four triplets, a 15-bit modulo field and an 8-bit wrap field. With these values, every triplet index can be reached, along with modulo lengths up to 0x8000, wrap rings of 2 to 256 words, and rollover at the 24-bit boundary. Random traffic keeps one triplet in each mode. The modulo length and the wrap size are changed every few hundred cycles. Directed cases cover the buffer edges, a step equal to the full modulo length, the bit-reversed sequence, reserved modifiers, and a load colliding with an update.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    REG_ADDR = 2'd0,
    REG_OFFS = 2'd1,
    REG_MODF = 2'd2,
    REG_NONE = 2'd3
  } regSelT;

  localparam int PICK_LIN  = 0;
  localparam int PICK_MOD  = 1;
  localparam int PICK_WRAP = 2;
  localparam int PICK_REV  = 3;
  localparam int PICK_W    = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic              commit;    // write nextAddr back
    logic [PICK_W-1:0] pick;      // one-hot result select
    logic              stepOffs;  // step comes from offset register
    logic              stepNeg;   // step is -1
  } aguStrobeT;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
#(
  parameter int AW    = 24,
  parameter int MODW  = 15,
  parameter int WRAPW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            updEn,
  input  logic [1:0]      updOp,
  input  logic [AW-1:0]   selModifier,
  output aguStrobeT       strobe
);

  localparam int HIW = AW - MODW - 1;   // bits above the wrap marker

  logic             isLin, isRev, isMod, isWrap;
  logic [WRAPW-1:0] wrapLow;
  logic [WRAPW-1:0] wrapLowInc;

  assign wrapLow    = selModifier[WRAPW-1:0];
  assign wrapLowInc = wrapLow + WRAPW'(1);

  always_comb begin
    isLin  = &selModifier;
    isRev  = (selModifier == '0);
    isMod  = (selModifier[AW-1:MODW] == '0) && !isRev;
    isWrap = (selModifier[AW-1:MODW+1] == HIW'(0))
          && selModifier[MODW]
          && (selModifier[MODW-1:WRAPW] == '0)
          && (wrapLow != '0)
          && ((wrapLow & wrapLowInc) == '0);
  end

  always_comb begin
    strobe          = '0;
    strobe.commit   = updEn;
    strobe.stepOffs = updOp[1];
    strobe.stepNeg  = (updOp == 2'b01);
    if (isRev)       strobe.pick[PICK_REV]  = 1'b1;
    else if (isMod)  strobe.pick[PICK_MOD]  = 1'b1;
    else if (isWrap) strobe.pick[PICK_WRAP] = 1'b1;
    else             strobe.pick[PICK_LIN]  = 1'b1;
  end

  // all-ones modifier never lands outside linear; select stays one-hot
  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(strobe.pick)); // R3

  AST_ALLONES_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (&selModifier) |-> !strobe.pick[PICK_MOD] && !strobe.pick[PICK_WRAP] && !strobe.pick[PICK_REV]); // R3

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int AW    = 24,
  parameter int NTRIP = 4,
  parameter int WRAPW = 8,
  localparam int IW   = (NTRIP > 1) ? $clog2(NTRIP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrEn,
  input  regSelT          wrSel,
  input  logic [IW-1:0]   wrIdx,
  input  logic [AW-1:0]   wrData,
  input  logic [IW-1:0]   updIdx,
  input  aguStrobeT       strobe,
  output logic [AW-1:0]   selModifier,
  output logic [AW-1:0]   curAddr,
  output logic [AW-1:0]   nextAddr
);

  logic [NTRIP-1:0][AW-1:0] addrQ, offsQ, modfQ;

  // ---------------- register file ----------------
  for (genvar t = 0; t < NTRIP; t++) begin : g_trip
    logic hitWr;
    assign hitWr = wrEn && (wrIdx == IW'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addrQ[t] <= '0;
        offsQ[t] <= '0;
        modfQ[t] <= '1;
      end else begin
        if (hitWr && wrSel == REG_ADDR)
          addrQ[t] <= wrData;
        else if (strobe.commit && updIdx == IW'(t))
          addrQ[t] <= nextAddr;
        if (hitWr && wrSel == REG_OFFS) offsQ[t] <= wrData;
        if (hitWr && wrSel == REG_MODF) modfQ[t] <= wrData;
      end
    end

    // untouched triplets keep their address
    AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(strobe.commit && updIdx == IW'(t)) && !hitWr) |=> $stable(addrQ[t])); // R7
  end

  logic [AW-1:0] curOffs;
  assign curAddr     = addrQ[updIdx];
  assign curOffs     = offsQ[updIdx];
  assign selModifier = modfQ[updIdx];

  // ---------------- step select ----------------
  logic [AW-1:0] stepVal;
  always_comb begin
    if (strobe.stepOffs)     stepVal = curOffs;
    else if (strobe.stepNeg) stepVal = '1;
    else                     stepVal = AW'(1);
  end

  // ---------------- forward offset adder ----------------
  logic [AW-1:0] fwdSum;
  assign fwdSum = curAddr + stepVal;

  // ---------------- reverse-carry adder ----------------
  logic [AW-1:0] revA, revS, revAcc, revOut;
  for (genvar b = 0; b < AW; b++) begin : g_rev
    assign revA[b]   = curAddr[AW-1-b];
    assign revS[b]   = stepVal[AW-1-b];
    assign revOut[b] = revAcc[AW-1-b];
  end
  assign revAcc = revA + revS;

  // ---------------- modulo correction ----------------
  logic [AW-1:0]   modMask, modBase, modTop, modLen, modCorr, modRes;
  logic [AW+1:0]   sumWide;
  logic            stepIsNeg, overTop, underBase;

  always_comb begin
    modMask[AW-1] = selModifier[AW-1];
    for (int k = AW-2; k >= 0; k--)
      modMask[k] = modMask[k+1] | selModifier[k];
  end

  assign stepIsNeg = stepVal[AW-1];
  assign modBase   = curAddr & ~modMask;
  assign modTop    = modBase + selModifier;
  assign modLen    = selModifier + AW'(1);
  assign sumWide   = {2'b00, curAddr} + {{2{stepVal[AW-1]}}, stepVal};
  assign overTop   = !stepIsNeg && (sumWide > {2'b00, modTop});
  assign underBase = stepIsNeg && ($signed(sumWide) < $signed({2'b00, modBase}));
  assign modCorr   = stepIsNeg ? (fwdSum + modLen) : (fwdSum - modLen);
  assign modRes    = (overTop || underBase) ? modCorr : fwdSum;

  // ---------------- multiple-wrap ----------------
  logic [AW-1:0] wrapMask, wrapRes;
  assign wrapMask = {{(AW-WRAPW){1'b0}}, selModifier[WRAPW-1:0]};
  assign wrapRes  = (curAddr & ~wrapMask) | (fwdSum & wrapMask);

  // ---------------- result select ----------------
  always_comb begin
    if (strobe.pick[PICK_REV])       nextAddr = revOut;
    else if (strobe.pick[PICK_MOD])  nextAddr = modRes;
    else if (strobe.pick[PICK_WRAP]) nextAddr = wrapRes;
    else                             nextAddr = fwdSum;
  end

  // ---------------- assertions ----------------
  logic            loadAddr, collide, curInBuf, nextInBuf, stepFits;
  logic [AW-1:0]   stepMag;
  assign loadAddr  = wrEn && (wrSel == REG_ADDR);
  assign collide   = loadAddr && strobe.commit && (wrIdx == updIdx);
  assign stepMag   = stepIsNeg ? (~stepVal + AW'(1)) : stepVal;
  assign stepFits  = ({1'b0, stepMag} <= ({1'b0, selModifier} + (AW+1)'(1)));
  assign curInBuf  = (curAddr >= modBase) && (curAddr <= modTop);
  assign nextInBuf = (nextAddr >= modBase) && (nextAddr <= modTop);

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> addrQ[$past(wrIdx)] == $past(wrData)); // R8

  AST_COMMIT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && !collide) |=> addrQ[$past(updIdx)] == $past(nextAddr)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.commit && !wrEn) |=> $stable(addrQ)); // R9

  AST_MOD_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && strobe.pick[PICK_MOD] && curInBuf && stepFits) |-> nextInBuf); // R4

  AST_WRAP_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && strobe.pick[PICK_WRAP]) |-> ((nextAddr ^ curAddr) & ~wrapMask) == '0); // R5

endmodule

// File: rtl/modulo_brev_agu.sv
module modulo_brev_agu
  import agu_pkg::*;
#(
  parameter int AW    = 24,
  parameter int NTRIP = 4,
  parameter int MODW  = 15,
  parameter int WRAPW = 8,
  localparam int IW   = (NTRIP > 1) ? $clog2(NTRIP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrEn,
  input  logic [1:0]      wrSel,
  input  logic [IW-1:0]   wrIdx,
  input  logic [AW-1:0]   wrData,
  input  logic            updEn,
  input  logic [IW-1:0]   updIdx,
  input  logic [1:0]      updOp,
  output logic [AW-1:0]   curAddr,
  output logic [AW-1:0]   nextAddr
);

  aguStrobeT     strobe;
  logic [AW-1:0] selModifier;

  agu_ctrl #(.AW(AW), .MODW(MODW), .WRAPW(WRAPW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .updEn       (updEn),
    .updOp       (updOp),
    .selModifier (selModifier),
    .strobe      (strobe)
  );

  agu_datapath #(.AW(AW), .NTRIP(NTRIP), .WRAPW(WRAPW)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrEn        (wrEn),
    .wrSel       (regSelT'(wrSel)),
    .wrIdx       (wrIdx),
    .wrData      (wrData),
    .updIdx      (updIdx),
    .strobe      (strobe),
    .selModifier (selModifier),
    .curAddr     (curAddr),
    .nextAddr    (nextAddr)
  );

endmodule

// File: tb/tb_modulo_brev_agu.sv
`timescale 1ns/1ps
module tb_modulo_brev_agu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd3;
  logic [1:0]  wrIdx = '0;
  logic [23:0] wrData = '0;
  logic        updEn = 1'b0;
  logic [1:0]  updIdx = '0;
  logic [1:0]  updOp = '0;
  logic [23:0] curAddr, nextAddr;

  int nTests = 0;
  int nFail  = 0;

  logic [23:0] mA [4];
  logic [23:0] mO [4];
  logic [23:0] mM [4];

  always #2.5 clk = ~clk;

  modulo_brev_agu dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrData(wrData), .updEn(updEn), .updIdx(updIdx), .updOp(updOp),
    .curAddr(curAddr), .nextAddr(nextAddr)
  );

  // 0 linear, 1 modulo, 2 wrap, 3 reverse
  function automatic int modeOf(input logic [23:0] m);
    logic [7:0] lb;
    lb = m[7:0];
    if (m == 24'd0) return 3;
    if (m <= 24'h7FFF) return 1;
    if (m[23:8] == 16'h0080 && lb != 0 && ((lb & (lb + 8'd1)) == 0)) return 2;
    return 0;
  endfunction

  function automatic logic [23:0] revAdd(input logic [23:0] a, input logic [23:0] b);
    logic [23:0] r;
    logic        c;
    logic [1:0]  t;
    c = 1'b0;
    for (int k = 23; k >= 0; k--) begin
      t = {1'b0, a[k]} + {1'b0, b[k]} + {1'b0, c};
      r[k] = t[0];
      c = t[1];
    end
    return r;
  endfunction

  function automatic logic [23:0] expNext(input logic [23:0] a, input logic [1:0] op,
                                         input logic [23:0] offs, input logic [23:0] m);
    logic [23:0] s, base, mask;
    int ss, mlen, sz, rel;
    s  = (op == 2'd0) ? 24'd1 : (op == 2'd1) ? 24'hFFFFFF : offs;
    ss = $signed(s);
    case (modeOf(m))
      1: begin
        mlen = int'(m) + 1;
        sz = 1;
        while (sz < mlen) sz = sz * 2;
        base = a & ~24'(sz - 1);
        rel = int'(a - base) + ss;
        if (rel > int'(m)) rel = rel - mlen;
        else if (rel < 0)  rel = rel + mlen;
        return base + 24'(rel);
      end
      2: begin
        mask = {16'd0, m[7:0]};
        return (a & ~mask) | ((a + s) & mask);
      end
      3: return revAdd(a, s);
      default: return a + s;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  // one clock with model tracking; curAddr and nextAddr checked before the edge
  task automatic cyc(input bit we, input logic [1:0] ws, input logic [1:0] wi, input logic [23:0] wd,
                     input bit ue, input logic [1:0] ui, input logic [1:0] uo);
    logic [23:0] e;
    string tg;
    @(negedge clk);
    wrEn = we; wrSel = ws; wrIdx = wi; wrData = wd;
    updEn = ue; updIdx = ui; updOp = uo;
    #1;
    e = expNext(mA[ui], uo, mO[ui], mM[ui]);
    check(curAddr == mA[ui], "R7 current address", curAddr, mA[ui]);
    if (ue) begin
      case (modeOf(mM[ui]))
        1: tg = "R4 modulo";
        2: tg = "R5 multiple wrap";
        3: tg = "R6 reverse carry";
        default: tg = "R3 linear";
      endcase
      check(nextAddr == e, tg, nextAddr, e);
    end
    @(posedge clk);
    if (ue) mA[ui] = e;
    if (we) begin
      case (ws)
        2'd0: mA[wi] = wd;
        2'd1: mO[wi] = wd;
        2'd2: mM[wi] = wd;
        default: ;
      endcase
    end
  endtask

  task automatic peek(input logic [1:0] i, input logic [23:0] exp, input string tag);
    @(negedge clk);
    wrEn = 0; updEn = 0; updIdx = i;
    #1;
    check(curAddr == exp, tag, curAddr, exp);
  endtask

  task automatic load(input logic [1:0] ws, input logic [1:0] wi, input logic [23:0] wd);
    cyc(1, ws, wi, wd, 0, 0, 0);
  endtask

  initial begin
    #(150000 * 5);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [23:0] revSeq [8];
    logic [23:0] m1, base1, lbw;
    int sz1, mlen1;
    void'($urandom(32'h1A2B3C));
    revSeq = '{24'd0, 24'd4, 24'd2, 24'd6, 24'd1, 24'd5, 24'd3, 24'd7};
    for (int i = 0; i < 4; i++) begin mA[i] = 0; mO[i] = 0; mM[i] = 24'hFFFFFF; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) peek(2'(i), 24'd0, "R1 reset address");
    cyc(0, 3, 0, 0, 1, 0, 0);
    peek(0, 24'd1, "R1 default linear increment");

    // R3 linear rollover, decrement, negative offset, reserved modifier
    load(0, 0, 24'hFFFFFF);
    cyc(0, 3, 0, 0, 1, 0, 0);
    peek(0, 24'd0, "R3 rollover");
    cyc(0, 3, 0, 0, 1, 0, 1);
    load(1, 0, 24'hFFFFF0);
    cyc(0, 3, 0, 0, 1, 0, 2);
    load(2, 0, 24'h009000);
    cyc(0, 3, 0, 0, 1, 0, 0);
    peek(0, 24'hFFFFF0, "R3 reserved modifier linear");

    // R2 wrSel=3 changes nothing
    load(3, 0, 24'h123456);
    peek(0, 24'hFFFFF0, "R2 ignored select");
    cyc(0, 3, 0, 0, 1, 0, 2);   // offset still FFFFF0 (model checks)

    // R6 bit-reversed sequence
    load(2, 3, 24'd0); load(0, 3, 24'd0); load(1, 3, 24'd4);
    for (int k = 0; k < 8; k++) begin
      peek(3, revSeq[k], "R6 bit-reverse order");
      cyc(0, 3, 0, 0, 1, 3, 2);
    end
    peek(3, 24'd0, "R6 sequence returns");

    // R4 modulo edges, length 10 at base 0x20
    load(2, 1, 24'd9); load(0, 1, 24'h29);
    cyc(0, 3, 0, 0, 1, 1, 0);
    peek(1, 24'h20, "R4 top wraps to base");
    cyc(0, 3, 0, 0, 1, 1, 1);
    peek(1, 24'h29, "R4 base wraps to top");
    load(1, 1, 24'd10);
    cyc(0, 3, 0, 0, 1, 1, 2);
    peek(1, 24'h29, "R4 full-length step");
    load(1, 1, 24'hFFFFF6);
    cyc(0, 3, 0, 0, 1, 1, 2);
    peek(1, 24'h29, "R4 full-length negative step");

    // R5 multiple wrap, ring of 16
    load(2, 2, 24'h00800F); load(0, 2, 24'hABC0E); load(1, 2, 24'd37);
    cyc(0, 3, 0, 0, 1, 2, 2);
    peek(2, 24'h0ABC03, "R5 multi wrap");

    // R8 load beats update
    cyc(1, 0, 2, 24'h555555, 1, 2, 0);
    peek(2, 24'h555555, "R8 load priority");

    // R9 idle hold
    repeat (3) cyc(0, 3, 0, 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) peek(2'(i), mA[i], "R9 idle hold");

    // random phase: trip0 linear, trip1 modulo, trip2 wrap, trip3 reverse
    load(2, 0, 24'hFFFFFF);
    for (int ph = 0; ph < 6; ph++) begin
      m1 = 24'(($urandom % 24'h7FFF) + 1);
      if (ph == 0) m1 = 24'h7FFF;
      if (ph == 1) m1 = 24'd1;
      mlen1 = int'(m1) + 1;
      sz1 = 1;
      while (sz1 < mlen1) sz1 = sz1 * 2;
      base1 = 24'($urandom) & ~24'(sz1 - 1);
      lbw = 24'((1 << (($urandom % 8) + 1)) - 1);
      load(2, 1, m1);
      load(0, 1, base1 + 24'($urandom % mlen1));
      load(1, 1, 24'(int'($urandom % (2 * mlen1 + 1)) - mlen1));
      load(2, 2, 24'h008000 | lbw);
      for (int it = 0; it < 300; it++) begin
        logic [1:0] wi, ws, ui, uo;
        logic [23:0] wd;
        bit we;
        we = ($urandom % 4) == 0;
        wi = 2'($urandom); ws = 2'($urandom); ui = 2'($urandom); uo = 2'($urandom);
        wd = 24'($urandom);
        if (ws == 2'd2) wd = mM[wi];
        if (wi == 2'd1 && ws == 2'd0) wd = base1 + 24'($urandom % mlen1);
        if (wi == 2'd1 && ws == 2'd1) wd = 24'(int'($urandom % (2 * mlen1 + 1)) - mlen1);
        cyc(we, ws, wi, wd, ($urandom % 5) != 0, ui, uo);
      end
      for (int i = 0; i < 4; i++) peek(2'(i), mA[i], "R2 random loads state");
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule